// File: doc/BRIEF.md
# Bus Arbitration Controller

This block lets one device with a fixed bus ID win ownership of a shared 8-bit parallel peripheral bus that has wired-OR lines. While its request input is high, it watches the busy, select and bus-reset lines until the bus is free. It then holds off for the required idle time. After that it drives busy together with the data line that matches its own ID. When the settle time has run out and no higher ID is present on the data lines, it drives select and reports the win to the selection logic that follows.

If a higher ID appears on the data lines during arbitration, the block lets go of its lines at once and goes back to watching for a free bus. Each delay is a cycle count derived from the clock frequency. The open-collector drivers are modelled as separate drive-enable outputs, so a high enable pulls the bus line to its asserted state. Parity is not looked at during arbitration and no parity line enters the block.

Top module: `bus_arbiter`

## Requirements
- R1: While rst_n is low, and right after it is released, bsy_oe, sel_oe, arb_won and every bit of data_oe are 0.
- R2: While arb_req is low the block drives nothing: bsy_oe and data_oe are 0 one clock after arb_req is sampled low.
- R3: The bus counts as free only when bsy_in, sel_in and rst_in (all active high) have been low through the two-flop synchronizers for DESKEW_CYC consecutive cycles. While any of them stays high, the block does not start arbitrating.
- R4: At least FREE_CYC cycles (800 ns, 200 cycles at 250 MHz) pass between the bus being seen free and bsy_oe rising. With DESKEW_CYC = 4 the latency from the pins going free to bsy_oe is at most FREE_CYC + 15 cycles. If the bus turns busy during the hold-off, no line is driven.
- R5: While arbitrating or after a win, data_oe has exactly one bit set: bit OWN_ID (0x20 for OWN_ID = 5). data_oe is 0 whenever bsy_oe is 0.
- R6: sel_oe rises no sooner than ARB_CYC cycles (2.2 µs, 550 cycles at 250 MHz) after bsy_oe rises, and no later than ARB_CYC + 5 cycles after it.
- R7: The device wins when no data line above bit OWN_ID is asserted; lower IDs on the bus do not matter. On a win, sel_oe and arb_won go high while bsy_oe and the ID bit stay driven.
- R8: When a data line above bit OWN_ID is asserted during arbitration, bsy_oe and data_oe fall to 0 within 5 cycles of that line changing at the pins. sel_oe is never asserted for that attempt.
- R9: After a loss, with arb_req still high, the block waits for the bus to become free again and then arbitrates anew.
- R10: With rst_in asserted for three consecutive cycles, all drive enables and arb_won are 0. No arbitration starts while rst_in is high.
- R11: After a win, the block keeps its lines until arb_req is sampled low. It then releases every line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arb_req | input | 1 | Request to own the bus; held high until finished |
| bsy_in | input | 1 | Busy line as seen on the bus, active high, asynchronous |
| sel_in | input | 1 | Select line as seen on the bus, active high, asynchronous |
| rst_in | input | 1 | Bus reset line, active high, asynchronous |
| data_in | input | DW | Data lines as seen on the bus, active high, asynchronous |
| bsy_oe | output | 1 | Drive enable for the busy line |
| sel_oe | output | 1 | Drive enable for the select line |
| data_oe | output | DW | Drive enables for the data lines |
| arb_won | output | 1 | Arbitration won; hand-over to the selection logic |

## Verification
Arbitration is run against several competitor patterns: none at all, only lower IDs driven at the same moment, and a higher ID that turns up partway through the settle time. Together these separate the compare that lets lower IDs pass from the one that backs off for higher IDs. A busy bus, a select line that rises during the hold-off, and an asserted bus reset each show that the free condition gates the start. The hold-off and settle latencies are measured against tight windows. This catches a wait that is cut short as well as a counter that runs late. A retry after a loss, and a fresh win after a bus reset, show that the block comes back to watching the bus in both cases.

// File: rtl/arb_pkg.sv
// Package: shared types and helpers for the bus arbitration controller.
// Assumes integral clock frequency in MHz and delays given in nanoseconds.
package arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,   // watching for a free bus
        ST_HOLDOFF = 2'd1,   // bus free, waiting out the idle time
        ST_ARB     = 2'd2,   // busy and ID bit driven, settling
        ST_WON     = 2'd3    // select driven, bus owned
    } arb_state_e;

    // Round a nanosecond delay up to whole clock cycles.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

endpackage

// File: rtl/bus_sync.sv
// Two-flop synchronizer for W asynchronous active-high bus lines.
// Assumes each line is stable long enough to be caught; resets to deasserted.
module bus_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_bit
            logic meta;
            logic stable;
            // Two-stage capture of one bus line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    meta   <= 1'b0;
                    stable <= 1'b0;
                end else begin
                    meta   <= d[i];
                    stable <= meta;
                end
            end
            assign q[i] = stable;
        end
    endgenerate
endmodule

// File: rtl/free_detect.sv
// Bus-free detector: flags the bus free once busy, select and bus reset
// have all been low for DESKEW_CYC consecutive synchronized cycles.
// Assumes inputs are already synchronized to clk.
module free_detect #(
    parameter int DESKEW_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bsy_s,
    input  logic sel_s,
    input  logic rst_s,
    output logic bus_free
);
    localparam int CW = $clog2(DESKEW_CYC + 1);

    logic [CW-1:0] quiet_cnt;
    logic          raw_free;

    assign raw_free = !bsy_s && !sel_s && !rst_s;

    // Count consecutive quiet cycles, saturating at the deskew limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !raw_free) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != CW'(DESKEW_CYC)) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    assign bus_free = raw_free && (quiet_cnt == CW'(DESKEW_CYC));
endmodule

// File: rtl/cycle_timer.sv
// Up-counter for phase timing: cleared on request, otherwise counts and
// saturates at its maximum. Assumes W is wide enough for the longest phase.
module cycle_timer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] count
);
    // Restart on clear, else advance until saturated.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            count <= '0;
        end else if (count != {W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/bus_arbiter.sv
// Bus arbitration controller: wins a shared wired-OR parallel bus for a
// device with fixed ID OWN_ID. Sequence: free detect, idle hold-off, drive
// busy and own ID bit, settle, compare against higher IDs, then drive select.
// Assumes open-collector drivers outside; outputs are drive enables.
module bus_arbiter #(
    parameter int DW         = 8,
    parameter int OWN_ID     = 5,
    parameter int CLK_MHZ    = 250,
    parameter int FREE_NS    = 800,
    parameter int SETTLE_NS  = 2200,
    parameter int DESKEW_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arb_req,
    input  logic          bsy_in,
    input  logic          sel_in,
    input  logic          rst_in,
    input  logic [DW-1:0] data_in,
    output logic          bsy_oe,
    output logic          sel_oe,
    output logic [DW-1:0] data_oe,
    output logic          arb_won
);
    import arb_pkg::*;

    localparam int FREE_CYC = int'(ns_to_cyc(FREE_NS, CLK_MHZ));
    localparam int ARB_CYC  = int'(ns_to_cyc(SETTLE_NS, CLK_MHZ));
    localparam int MAX_CYC  = (FREE_CYC > ARB_CYC) ? FREE_CYC : ARB_CYC;
    localparam int TW       = $clog2(MAX_CYC + 1);
    localparam logic [DW-1:0] OWN_MASK   = DW'(1) << OWN_ID;
    localparam logic [DW-1:0] ABOVE_MASK = ~((OWN_MASK << 1) - DW'(1));

    logic          bsy_s, sel_s, rst_s;
    logic [DW-1:0] data_s;
    logic          bus_free;
    logic [TW-1:0] tcount;
    logic          outranked;
    arb_state_e    state, state_nx;

    bus_sync #(.W(3)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bsy_in, sel_in, rst_in}),
        .q     ({bsy_s, sel_s, rst_s})
    );

    bus_sync #(.W(DW)) u_data_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (data_in),
        .q     (data_s)
    );

    free_detect #(.DESKEW_CYC(DESKEW_CYC)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .bsy_s    (bsy_s),
        .sel_s    (sel_s),
        .rst_s    (rst_s),
        .bus_free (bus_free)
    );

    cycle_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_nx != state),
        .count (tcount)
    );

    assign outranked = (data_s & ABOVE_MASK) != '0;

    // Next-state decision for the arbitration sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (arb_req && bus_free) state_nx = ST_HOLDOFF;
            end
            ST_HOLDOFF: begin
                if (!arb_req || !bus_free)            state_nx = ST_IDLE;
                else if (tcount == TW'(FREE_CYC - 1)) state_nx = ST_ARB;
            end
            ST_ARB: begin
                if (!arb_req || outranked)           state_nx = ST_IDLE;
                else if (tcount == TW'(ARB_CYC - 1)) state_nx = ST_WON;
            end
            ST_WON: begin
                if (!arb_req) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
        if (rst_s) state_nx = ST_IDLE;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Drive enables decoded from the registered state.
    always_comb begin
        bsy_oe  = (state == ST_ARB) || (state == ST_WON);
        sel_oe  = (state == ST_WON);
        arb_won = (state == ST_WON);
        data_oe = bsy_oe ? OWN_MASK : '0;
    end
endmodule

// File: rtl/bus_arbiter_chk.sv
// Checker for the bus arbitration controller: timing windows are tracked
// with counters so no deep history is unrolled. Bound to every bus_arbiter.
module bus_arbiter_chk #(
    parameter int DW       = 8,
    parameter int OWN_ID   = 5,
    parameter int FREE_CYC = 200,
    parameter int ARB_CYC  = 550
) (
    input logic          clk,
    input logic          rst_n,
    input logic          arb_req,
    input logic          bsy_in,
    input logic          sel_in,
    input logic          rst_in,
    input logic          bsy_oe,
    input logic          sel_oe,
    input logic [DW-1:0] data_oe,
    input logic          arb_won
);
    localparam logic [DW-1:0] OWN_MASK = DW'(1) << OWN_ID;

    logic [15:0] quiet_run;
    logic [15:0] settle_run;

    // Consecutive cycles with all control lines free at the pins.
    always_ff @(posedge clk) begin
        if (!rst_n || bsy_in || sel_in || rst_in) quiet_run <= '0;
        else if (quiet_run != 16'hFFFF)           quiet_run <= quiet_run + 1'b1;
    end

    // Cycles spent driving busy without select.
    always_ff @(posedge clk) begin
        if (!rst_n || !bsy_oe || sel_oe) settle_run <= '0;
        else if (settle_run != 16'hFFFF) settle_run <= settle_run + 1'b1;
    end

    AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!arb_req) |-> (!bsy_oe && data_oe == '0)); // R2
    AST_HOLDOFF_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bsy_oe) |-> (quiet_run >= 16'(FREE_CYC))); // R4
    AST_ONE_ID_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe != '0) |-> (data_oe == OWN_MASK && bsy_oe)); // R5
    AST_SETTLE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_oe) |-> (settle_run >= 16'(ARB_CYC))); // R6
    AST_SEL_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        sel_oe |-> (bsy_oe && arb_won)); // R7
    AST_BUS_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_in, 3) && $past(rst_in, 2) && $past(rst_in))
        |-> (!bsy_oe && !sel_oe && !arb_won && data_oe == '0)); // R10
endmodule

bind bus_arbiter bus_arbiter_chk #(
    .DW       (DW),
    .OWN_ID   (OWN_ID),
    .FREE_CYC (FREE_CYC),
    .ARB_CYC  (ARB_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .arb_req (arb_req),
    .bsy_in  (bsy_in),
    .sel_in  (sel_in),
    .rst_in  (rst_in),
    .bsy_oe  (bsy_oe),
    .sel_oe  (sel_oe),
    .data_oe (data_oe),
    .arb_won (arb_won)
);

// File: tb/tb_bus_arbiter.sv
// Scoreboard bench: stimulus tasks push the expected arbitration outcome,
// a monitor pops and compares as wins and losses appear on the outputs.
module tb_bus_arbiter;
    localparam int FREE_CYC = 200;
    localparam int ARB_CYC  = 550;

    typedef enum int {EV_WIN = 1, EV_LOSE = 2} ev_e;

    logic       clk = 1'b0;
    logic       rst_n, arb_req;
    logic       opp_bsy, opp_sel, bus_rst;
    logic [7:0] opp_data;
    logic       bsy_in, sel_in;
    logic [7:0] data_in;
    logic       bsy_oe, sel_oe, arb_won;
    logic [7:0] data_oe;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  p_bsy   = 0;
    bit  p_sel   = 0;
    ev_e exp_q[$];

    always #2 clk = ~clk;

    // Wired-OR bus: this device plus a modelled competitor.
    assign bsy_in  = bsy_oe | opp_bsy;
    assign sel_in  = sel_oe | opp_sel;
    assign data_in = data_oe | opp_data;

    bus_arbiter dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .arb_req (arb_req),
        .bsy_in  (bsy_in),
        .sel_in  (sel_in),
        .rst_in  (bus_rst),
        .data_in (data_in),
        .bsy_oe  (bsy_oe),
        .sel_oe  (sel_oe),
        .data_oe (data_oe),
        .arb_won (arb_won)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_ev(input ev_e e);
        exp_q.push_back(e);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_bsy(input bit lvl, input int lim, output int n);
        n = 0;
        while (bsy_oe != lvl && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_sel(input int lim, output int n);
        n = 0;
        while (!sel_oe && n < lim) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Monitor: pops one expected outcome per win or loss seen.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sel_oe && !p_sel) begin
                if (exp_q.size() == 0) check(0, "R7 unexpected win", EV_WIN, 0);
                else check(exp_q.pop_front() == EV_WIN, "R7 outcome win", EV_WIN, EV_WIN);
            end else if (!bsy_oe && p_bsy && !p_sel) begin
                if (exp_q.size() == 0) check(0, "R8 unexpected loss", EV_LOSE, 0);
                else check(exp_q.pop_front() == EV_LOSE, "R8 outcome loss", EV_LOSE, EV_LOSE);
            end
        end
        p_bsy = bsy_oe;
        p_sel = sel_oe;
    end

    task automatic report;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        check(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int n;
        rst_n = 0; arb_req = 0; opp_bsy = 0; opp_sel = 0; bus_rst = 0; opp_data = 8'h00;
        cycles(5);
        check(!bsy_oe && !sel_oe && !arb_won && data_oe == 0, "R1 reset outputs", int'(bsy_oe), 0);
        rst_n = 1;
        cycles(1);
        check(!bsy_oe && data_oe == 0, "R1 after reset", int'(data_oe), 0);

        // R2: no request, free bus.
        cycles(400);
        check(!bsy_oe && data_oe == 0, "R2 no request no drive", int'(bsy_oe), 0);

        // R3: request while bus busy.
        opp_bsy = 1; arb_req = 1;
        cycles(400);
        check(!bsy_oe, "R3 busy bus blocks", int'(bsy_oe), 0);

        // R4/R5/R6/R7: free bus, lower IDs compete.
        opp_bsy = 0;
        wait_bsy(1, 400, n);
        check(n >= FREE_CYC && n <= FREE_CYC + 15, "R4 hold-off latency", n, FREE_CYC);
        check(data_oe == 8'h20, "R5 own ID bit", int'(data_oe), 32);
        expect_ev(EV_WIN);
        opp_bsy = 1; opp_data = 8'h05;
        wait_sel(700, n);
        check(n >= ARB_CYC && n <= ARB_CYC + 5, "R6 settle window", n, ARB_CYC);
        check(arb_won && bsy_oe && data_oe == 8'h20, "R7 win holds lines", int'(arb_won), 1);
        opp_bsy = 0; opp_data = 8'h00;
        cycles(20);
        check(sel_oe && bsy_oe, "R11 hold while requested", int'(sel_oe), 1);
        arb_req = 0;
        cycles(2);
        check(!bsy_oe && !sel_oe && !arb_won && data_oe == 0, "R11 release on drop", int'(bsy_oe), 0);

        // R4: bus turns busy during the hold-off.
        cycles(20);
        arb_req = 1;
        cycles(100);
        opp_sel = 1;
        cycles(400);
        check(!bsy_oe, "R4 busy during hold-off", int'(bsy_oe), 0);
        opp_sel = 0;

        // R8: higher ID appears mid-settle.
        wait_bsy(1, 400, n);
        check(n >= FREE_CYC && n <= FREE_CYC + 15, "R4 retry latency", n, FREE_CYC);
        cycles(50);
        expect_ev(EV_LOSE);
        opp_bsy = 1; opp_data = 8'h80;
        wait_bsy(0, 20, n);
        check(n <= 5, "R8 withdraw latency", n, 3);
        check(data_oe == 0 && !sel_oe, "R8 lines released", int'(data_oe), 0);
        cycles(300);
        check(!bsy_oe, "R9 waits while busy", int'(bsy_oe), 0);

        // R9: retry after the winner leaves.
        expect_ev(EV_WIN);
        opp_bsy = 0; opp_data = 8'h00;
        wait_bsy(1, 400, n);
        check(n <= FREE_CYC + 15, "R9 retry starts", n, FREE_CYC);
        wait_sel(700, n);
        check(arb_won == 1, "R9 retry wins", int'(arb_won), 1);

        // R10: bus reset while owning the bus.
        bus_rst = 1;
        wait_bsy(0, 20, n);
        check(n <= 4 && !sel_oe && !arb_won, "R10 reset release", n, 3);
        cycles(400);
        check(!bsy_oe && data_oe == 0, "R10 no start under reset", int'(bsy_oe), 0);
        expect_ev(EV_WIN);
        bus_rst = 0;
        wait_bsy(1, 400, n);
        wait_sel(700, n);
        check(arb_won == 1, "R10 win after reset", int'(arb_won), 1);
        arb_req = 0;
        cycles(5);
        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        report();
    end
endmodule